// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Controller

This block sits between a 32-bit register bus and a one-time-programmable fuse array. Software selects a fuse word through a control register. It can then sense that word into a read-result register, or burn a 32-bit value into it. Burning is allowed only after a 16-bit unlock key has been written into the top half of the control register. A third operation walks every fuse word in turn and copies each one into a shadow copy, which the bus can read through a window.

Each operation is run by a small sequencer in three phases: a relax interval, a strobe, and a second relax interval. The strobe drives the array's read or program pin. The lengths of all three phases come from a software-loaded timing register and are counted in clock cycles. A busy flag is high for the whole operation. A sticky error flag records any command that was rejected. The array is external and is reached through a plain address, strobe and data port.

Top module: `fuse_ctl`

## Requirements
- R1: After reset the control register reads 0, the timing register reads 0x0003_1005, the read-result register reads 0 and busy is low.
- R2: The control register is at offset 0x00. A write to offset 0x04 ORs the written bits into it, and a write to offset 0x08 clears the written bits. Address is in bits 6:0, busy in bit 8, error in bit 9, reload in bit 10 and the unlock field in bits 31:16.
- R3: Writing 1 to bit 0 at offset 0x30 senses the addressed word. When busy falls, the sensed value is readable at offset 0x40.
- R4: Every operation runs relax, strobe, relax. Relax lasts the count in timing bits 15:12. The strobe lasts the count in timing bits 21:16 for a sense and bits 11:0 for a burn, and a count of 0 gives one cycle. Busy is high for exactly 2·relax + strobe cycles, and the read and program strobes are never high together.
- R5: With the unlock field equal to 0x3E77, a write to offset 0x20 burns the written value into the addressed word. The program strobe is driven with that value.
- R6: The unlock field reads 0 after a burn completes.
- R7: A write to offset 0x20 without the key sets error, raises neither busy nor a strobe, and leaves the array unchanged.
- R8: A sense, burn or reload command issued while busy sets error and does not disturb the running operation's length or result.
- R9: Error stays set through plain control writes and is cleared only by writing bit 9 at offset 0x08.
- R10: Setting bit 10 copies every fuse word, in ascending order, into shadow entries that are readable at offset 0x400 + 4·word. The bit clears itself when the pass ends, and busy lasts the whole pass.
- R11: Bit 8 of the control register cannot be written.
- R12: The word address is captured when an operation starts, so changing the control address while busy has no effect on that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 12 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| busy | output | 1 | Operation in progress |
| fuseAddr | output | 7 | Fuse word address |
| fuseRdStrobe | output | 1 | Array sense strobe |
| fusePgmStrobe | output | 1 | Array burn strobe |
| fusePgmData | output | 32 | Bits to burn |
| fuseRdData | input | 32 | Sensed word from the array |

## Verification
Senses are run from a table that pairs different words with different timing settings. The settings include zero relax, a zero strobe count, the largest relax count and the largest read strobe. Measured busy and strobe widths therefore separate the relax count from the strobe count, and the zero cases are covered. The burn is checked by a later sense, which shows that bits OR into the word. A second burn attempt without the key shows that the unlock field is lost after the first burn. A command issued during a long sense, together with a change of address, shows that the result and the remaining length stay intact. The full reload pass is checked against every word, including the one that was burned.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_CSET  = 8'h04;
  localparam logic [7:0] OFS_CCLR  = 8'h08;
  localparam logic [7:0] OFS_TIME  = 8'h10;
  localparam logic [7:0] OFS_PDATA = 8'h20;
  localparam logic [7:0] OFS_RCMD  = 8'h30;
  localparam logic [7:0] OFS_RDATA = 8'h40;

  typedef struct packed {
    logic capRead;
    logic capShadow;
    logic clrUnlock;
    logic clrReload;
    logic errSet;
  } ctlStrobes_t;

  typedef enum logic [1:0] {PH_IDLE, PH_RLX1, PH_STRB, PH_RLX2} phase_t;
  typedef enum logic [1:0] {OP_READ, OP_PROG, OP_RELOAD} op_t;
endpackage

// File: rtl/fuse_ctl_regs.sv
module fuse_ctl_regs
  import fuse_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned BUS_AW     = 12,
  parameter logic [31:0] TIMING_RST = 32'h0003_1005
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [BUS_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              busy,
  input  ctlStrobes_t       stb,
  input  logic [31:0]       fuseRdData,
  input  logic [ADDR_W-1:0] opAddr,
  output logic              cmdRead,
  output logic              cmdProg,
  output logic              cmdReload,
  output logic              reloadBit,
  output logic              errBit,
  output logic              keyOk,
  output logic [ADDR_W-1:0] ctrlAddr,
  output logic [3:0]        relaxCnt,
  output logic [5:0]        rdStrCnt,
  output logic [11:0]       pgmStrCnt,
  output logic [31:0]       pgmData
);
  localparam int unsigned WORDS     = 1 << ADDR_W;
  localparam logic [31:0] ADDR_M    = (32'd1 << ADDR_W) - 32'd1;
  localparam logic [31:0] HELD_M    = 32'hFFFF_0400;  // unlock field and reload bit

  logic [31:0] ctrlQ, ctrlNew, ctrlD, wrMask;
  logic [21:0] timeQ;
  logic [31:0] dataQ, readQ;
  logic [31:0] shadowMem [WORDS];

  logic isReg, isShadow, wrCtrl, wrSet, wrClr, wrTime, wrPdata, wrRcmd;

  assign isReg    = (regAddr[BUS_AW-1:8] == '0);
  assign isShadow = (regAddr[BUS_AW-1 -: 2] == 2'b01);
  assign wrCtrl   = regWe && isReg && (regAddr[7:0] == OFS_CTRL);
  assign wrSet    = regWe && isReg && (regAddr[7:0] == OFS_CSET);
  assign wrClr    = regWe && isReg && (regAddr[7:0] == OFS_CCLR);
  assign wrTime   = regWe && isReg && (regAddr[7:0] == OFS_TIME);
  assign wrPdata  = regWe && isReg && (regAddr[7:0] == OFS_PDATA);
  assign wrRcmd   = regWe && isReg && (regAddr[7:0] == OFS_RCMD);

  assign cmdRead   = wrRcmd && regWdata[0];
  assign cmdProg   = wrPdata;
  assign cmdReload = (wrCtrl || wrSet) && regWdata[10];

  always_comb begin
    if (wrSet)      ctrlNew = ctrlQ | regWdata;
    else if (wrClr) ctrlNew = ctrlQ & ~regWdata;
    else            ctrlNew = regWdata;
    // the key and reload request are frozen while an operation runs
    wrMask = busy ? ADDR_M : (ADDR_M | HELD_M);
    ctrlD  = ctrlQ;
    if (wrCtrl || wrSet || wrClr) ctrlD = (ctrlQ & ~wrMask) | (ctrlNew & wrMask);
    if (wrClr && regWdata[9]) ctrlD[9] = 1'b0;
    if (stb.clrUnlock)        ctrlD[31:16] = '0;
    if (stb.clrReload)        ctrlD[10] = 1'b0;
    if (stb.errSet)           ctrlD[9] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      timeQ <= TIMING_RST[21:0];
      dataQ <= '0;
      readQ <= '0;
    end else begin
      ctrlQ <= ctrlD;
      if (wrTime)            timeQ <= regWdata[21:0];
      if (wrPdata && !busy)  dataQ <= regWdata;
      if (stb.capRead)       readQ <= fuseRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.capShadow) shadowMem[opAddr] <= fuseRdData;
  end

  always_comb begin
    regRdata = '0;
    if (isShadow) regRdata = shadowMem[regAddr[ADDR_W+1:2]];
    else if (isReg) begin
      case (regAddr[7:0])
        OFS_CTRL, OFS_CSET, OFS_CCLR: begin
          regRdata    = ctrlQ;
          regRdata[8] = busy;
        end
        OFS_TIME:  regRdata = {10'd0, timeQ};
        OFS_PDATA: regRdata = dataQ;
        OFS_RDATA: regRdata = readQ;
        default:   regRdata = '0;
      endcase
    end
  end

  assign reloadBit = ctrlQ[10];
  assign errBit    = ctrlQ[9];
  assign keyOk     = (ctrlQ[31:16] == UNLOCK_KEY);
  assign ctrlAddr  = ctrlQ[ADDR_W-1:0];
  assign relaxCnt  = timeQ[15:12];
  assign rdStrCnt  = timeQ[21:16];
  assign pgmStrCnt = timeQ[11:0];
  assign pgmData   = dataQ;
endmodule

// File: rtl/fuse_ctl_seq.sv
module fuse_ctl_seq
  import fuse_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdRead,
  input  logic              cmdProg,
  input  logic              cmdReload,
  input  logic              reloadBit,
  input  logic              keyOk,
  input  logic [ADDR_W-1:0] ctrlAddr,
  input  logic [3:0]        relaxCnt,
  input  logic [5:0]        rdStrCnt,
  input  logic [11:0]       pgmStrCnt,
  output logic              busy,
  output logic [ADDR_W-1:0] opAddr,
  output logic              fuseRdStrobe,
  output logic              fusePgmStrobe,
  output ctlStrobes_t       stb
);
  phase_t            phaseQ, phaseD;
  op_t               opQ, opD;
  logic [11:0]       cntQ, cntD, relaxM1, strbM1;
  logic [ADDR_W-1:0] addrQ, addrD;
  logic              goD, finD;

  function automatic logic [11:0] strobeLast(op_t op, logic [11:0] pgmLen, logic [5:0] rdLen);
    logic [11:0] len;
    len = (op == OP_PROG) ? pgmLen : {6'd0, rdLen};
    return (len == 12'd0) ? 12'd0 : len - 12'd1;
  endfunction

  assign relaxM1 = {8'd0, relaxCnt} - 12'd1;

  always_comb begin
    phaseD = phaseQ;
    opD    = opQ;
    cntD   = cntQ;
    addrD  = addrQ;
    stb    = '0;
    goD    = 1'b0;
    finD   = 1'b0;
    strbM1 = '0;
    if (phaseQ == PH_IDLE) begin
      if (cmdProg && keyOk) begin
        opD = OP_PROG;  addrD = ctrlAddr;  goD = 1'b1;
      end else if (cmdProg) begin
        stb.errSet = 1'b1;
      end else if (cmdRead) begin
        opD = OP_READ;  addrD = ctrlAddr;  goD = 1'b1;
      end else if (reloadBit) begin
        opD = OP_RELOAD;  addrD = '0;  goD = 1'b1;
      end
    end else begin
      if (cmdProg || cmdRead || cmdReload) stb.errSet = 1'b1;
      if (cntQ != 12'd0) cntD = cntQ - 12'd1;
      else begin
        case (phaseQ)
          PH_RLX1: begin
            phaseD = PH_STRB;
            cntD   = strobeLast(opQ, pgmStrCnt, rdStrCnt);
          end
          PH_STRB: begin
            stb.capRead   = (opQ == OP_READ);
            stb.capShadow = (opQ == OP_RELOAD);
            if (relaxCnt != 4'd0) begin
              phaseD = PH_RLX2;
              cntD   = relaxM1;
            end else finD = 1'b1;
          end
          default: finD = 1'b1;
        endcase
      end
    end
    if (finD) begin
      if (opQ == OP_RELOAD && addrQ != '1) begin
        addrD = addrQ + 1'b1;
        goD   = 1'b1;
      end else begin
        phaseD        = PH_IDLE;
        stb.clrUnlock = (opQ == OP_PROG);
        stb.clrReload = (opQ == OP_RELOAD);
      end
    end
    if (goD) begin
      strbM1 = strobeLast(opD, pgmStrCnt, rdStrCnt);
      if (relaxCnt != 4'd0) begin
        phaseD = PH_RLX1;
        cntD   = relaxM1;
      end else begin
        phaseD = PH_STRB;
        cntD   = strbM1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      opQ    <= OP_READ;
      cntQ   <= '0;
      addrQ  <= '0;
    end else begin
      phaseQ <= phaseD;
      opQ    <= opD;
      cntQ   <= cntD;
      addrQ  <= addrD;
    end
  end

  assign busy          = (phaseQ != PH_IDLE);
  assign opAddr        = addrQ;
  assign fuseRdStrobe  = (phaseQ == PH_STRB) && (opQ != OP_PROG);
  assign fusePgmStrobe = (phaseQ == PH_STRB) && (opQ == OP_PROG);
endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
  import fuse_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned BUS_AW     = 12,
  parameter logic [31:0] TIMING_RST = 32'h0003_1005
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [BUS_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              busy,
  output logic [ADDR_W-1:0] fuseAddr,
  output logic              fuseRdStrobe,
  output logic              fusePgmStrobe,
  output logic [31:0]       fusePgmData,
  input  logic [31:0]       fuseRdData
);
  ctlStrobes_t       stb;
  logic              cmdRead, cmdProg, cmdReload, reloadBit, errBit, keyOk;
  logic [ADDR_W-1:0] ctrlAddr, opAddr;
  logic [3:0]        relaxCnt;
  logic [5:0]        rdStrCnt;
  logic [11:0]       pgmStrCnt;

  fuse_ctl_regs #(.ADDR_W(ADDR_W), .BUS_AW(BUS_AW), .TIMING_RST(TIMING_RST)) uRegs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .busy(busy), .stb(stb), .fuseRdData(fuseRdData), .opAddr(opAddr),
    .cmdRead(cmdRead), .cmdProg(cmdProg), .cmdReload(cmdReload), .reloadBit(reloadBit),
    .errBit(errBit), .keyOk(keyOk), .ctrlAddr(ctrlAddr), .relaxCnt(relaxCnt),
    .rdStrCnt(rdStrCnt), .pgmStrCnt(pgmStrCnt), .pgmData(fusePgmData)
  );

  fuse_ctl_seq #(.ADDR_W(ADDR_W)) uSeq (
    .clk(clk), .rstN(rstN), .cmdRead(cmdRead), .cmdProg(cmdProg), .cmdReload(cmdReload),
    .reloadBit(reloadBit), .keyOk(keyOk), .ctrlAddr(ctrlAddr), .relaxCnt(relaxCnt),
    .rdStrCnt(rdStrCnt), .pgmStrCnt(pgmStrCnt), .busy(busy), .opAddr(opAddr),
    .fuseRdStrobe(fuseRdStrobe), .fusePgmStrobe(fusePgmStrobe), .stb(stb)
  );

  assign fuseAddr = opAddr;
endmodule

// File: rtl/fuse_ctl_chk.sv
module fuse_ctl_chk #(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              fuseRdStrobe,
  input logic              fusePgmStrobe,
  input logic [ADDR_W-1:0] fuseAddr,
  input logic              keyOk,
  input logic              errBit,
  input logic              clrWr,
  input logic              cmdRead,
  input logic              cmdProg,
  input logic              reloadBit
);
  // R4: the two strobes never overlap
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fuseRdStrobe, fusePgmStrobe}));

  // R4: a strobe only appears inside a busy operation
  assert_strobe_in_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fuseRdStrobe || fusePgmStrobe) |-> busy);

  // R7: burning happens only under a valid key
  assert_pgm_keyed_R7: assert property (@(posedge clk) disable iff (!rstN)
    fusePgmStrobe |-> keyOk);

  // R9: error survives everything but the clear alias
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errBit && !clrWr) |=> errBit);

  // R12: the word address does not move during a single-word operation
  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !reloadBit) |=> (!busy || $stable(fuseAddr)));

  // R3: busy only starts in response to a command
  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdRead || cmdProg || reloadBit));
endmodule

bind fuse_ctl fuse_ctl_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .fuseRdStrobe(fuseRdStrobe),
  .fusePgmStrobe(fusePgmStrobe), .fuseAddr(fuseAddr), .keyOk(keyOk), .errBit(errBit),
  .clrWr(regWe && (regAddr == 12'h008) && regWdata[9]),
  .cmdRead(cmdRead), .cmdProg(cmdProg), .reloadBit(reloadBit)
);

// File: tb/sim_fuse_ctl.sv
module sim_fuse_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 128;
  localparam logic [11:0] A_CTRL = 12'h000, A_CSET = 12'h004, A_CCLR = 12'h008,
                          A_TIME = 12'h010, A_PDATA = 12'h020, A_RCMD = 12'h030,
                          A_RDATA = 12'h040, A_SHADOW = 12'h400;
  // word[16:10], relax[9:6], read strobe[5:0]
  localparam logic [16:0] VEC [6] = '{
    {7'd0,   4'd1,  6'd3},
    {7'd5,   4'd0,  6'd4},
    {7'd17,  4'd2,  6'd0},
    {7'd63,  4'd3,  6'd7},
    {7'd127, 4'd0,  6'd0},
    {7'd64,  4'd15, 6'd63}
  };

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata, fusePgmData, fuseRdData;
  logic [6:0]  fuseAddr;
  logic        busy, fuseRdStrobe, fusePgmStrobe;
  logic [31:0] fuseArr [WORDS];
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_ctl u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .busy(busy), .fuseAddr(fuseAddr), .fuseRdStrobe(fuseRdStrobe),
    .fusePgmStrobe(fusePgmStrobe), .fusePgmData(fusePgmData), .fuseRdData(fuseRdData)
  );

  function automatic logic [31:0] fuseInit(int i);
    logic [7:0] b;
    b = i[7:0];
    return {~b, b ^ 8'h3C, 8'hA5 ^ {b[6:0], 1'b0}, b};
  endfunction

  // array model: bits can only go from 0 to 1
  assign fuseRdData = fuseArr[fuseAddr];
  always @(posedge clk) begin
    if (!rstN) for (int i = 0; i < WORDS; i++) fuseArr[i] <= fuseInit(i);
    else if (fusePgmStrobe) fuseArr[fuseAddr] <= fuseArr[fuseAddr] | fusePgmData;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWr(logic [11:0] a, logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic busRd(logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic runOp(output int nBusy, output int nRd, output int nPgm);
    nBusy = 0; nRd = 0; nPgm = 0;
    while (busy) begin
      nBusy++;
      if (fuseRdStrobe) nRd++;
      if (fusePgmStrobe) nPgm++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d, expW;
    int nB, nR, nP, bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    busRd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0);
    busRd(A_TIME, d);  chk("R1 timing", d, 32'h0003_1005);
    busRd(A_RDATA, d); chk("R1 rdata", d, 32'h0);
    chk("R1 busy", {31'd0, busy}, 32'h0);

    // R3, R4: sense table
    for (int k = 0; k < 6; k++) begin
      logic [6:0] w; logic [3:0] r; logic [5:0] s;
      w = VEC[k][16:10]; r = VEC[k][9:6]; s = VEC[k][5:0];
      busWr(A_TIME, {10'd0, s, r, 12'd5});
      busWr(A_CTRL, {25'd0, w});
      busWr(A_RCMD, 32'h1);
      runOp(nB, nR, nP);
      chk("R4 busy length", nB, 2 * r + ((s == 0) ? 1 : s));
      chk("R4 read strobe width", nR, (s == 0) ? 1 : s);
      chk("R4 no program strobe", nP, 0);
      busRd(A_RDATA, d); chk("R3 sensed word", d, fuseInit(w));
    end

    // R2: set and clear aliases
    busWr(A_CTRL, 32'h5);
    busWr(A_CSET, 32'h3);
    busRd(A_CTRL, d); chk("R2 set alias", d, 32'h7);
    busWr(A_CCLR, 32'h1);
    busRd(A_CTRL, d); chk("R2 clear alias", d, 32'h6);

    // R11: busy bit not writable
    busWr(A_CTRL, 32'h106);
    busRd(A_CTRL, d); chk("R11 busy bit", d, 32'h6);
    chk("R11 busy port", {31'd0, busy}, 32'h0);

    // R5, R6: keyed burn
    busWr(A_TIME, {10'd0, 6'd3, 4'd2, 12'd6});
    busWr(A_CTRL, {16'h3E77, 16'd10});
    busWr(A_PDATA, 32'h0000_F00F);
    runOp(nB, nR, nP);
    chk("R5 program strobe width", nP, 6);
    chk("R5 busy length", nB, 10);
    busRd(A_CTRL, d); chk("R6 unlock cleared", {16'd0, d[31:16]}, 32'h0);
    expW = fuseInit(10) | 32'h0000_F00F;
    busWr(A_RCMD, 32'h1);
    runOp(nB, nR, nP);
    busRd(A_RDATA, d); chk("R5 burned word", d, expW);

    // R7: burn without key
    busWr(A_PDATA, 32'hFFFF_FFFF);
    chk("R7 no busy after stale key", {31'd0, busy}, 32'h0);
    busRd(A_CTRL, d); chk("R7 error after stale key", {31'd0, d[9]}, 32'h1);
    busWr(A_CTRL, {16'h1234, 16'd10});
    busWr(A_PDATA, 32'hFFFF_FFFF);
    chk("R7 no busy bad key", {31'd0, busy}, 32'h0);
    busRd(A_CTRL, d); chk("R9 error kept over plain write", {31'd0, d[9]}, 32'h1);
    busWr(A_CSET, 32'h0);
    busRd(A_CTRL, d); chk("R9 error kept over set alias", {31'd0, d[9]}, 32'h1);
    busWr(A_CCLR, 32'h200);
    busRd(A_CTRL, d); chk("R9 error cleared", {31'd0, d[9]}, 32'h0);
    busWr(A_RCMD, 32'h1);
    runOp(nB, nR, nP);
    chk("R7 no strobe from rejected burn", nP, 0);
    busRd(A_RDATA, d); chk("R7 array unchanged", d, expW);

    // R8, R12: commands and address change while busy
    busWr(A_TIME, {10'd0, 6'd20, 4'd1, 12'd6});
    busWr(A_CTRL, 32'h3);
    busWr(A_RCMD, 32'h1);
    busWr(A_CTRL, 32'h7);
    busWr(A_RCMD, 32'h1);
    runOp(nB, nR, nP);
    chk("R8 remaining busy length", nB, 20);
    busRd(A_RDATA, d); chk("R12 result from start address", d, fuseInit(3));
    busRd(A_CTRL, d); chk("R8 error on busy command", {31'd0, d[9]}, 32'h1);
    chk("R12 new address stored", {25'd0, d[6:0]}, 32'h7);
    busWr(A_CCLR, 32'h200);

    // R10: shadow reload pass
    busWr(A_TIME, {10'd0, 6'd1, 4'd0, 12'd6});
    busWr(A_CSET, 32'h400);
    @(negedge clk);
    runOp(nB, nR, nP);
    chk("R10 busy over whole pass", nB, WORDS);
    chk("R10 one strobe per word", nR, WORDS);
    busRd(A_CTRL, d); chk("R10 reload bit self-clears", {31'd0, d[10]}, 32'h0);
    busRd(A_SHADOW + 12'd40, d); chk("R10 burned word shadow", d, expW);
    bad = 0;
    for (int i = 0; i < WORDS; i++) begin
      busRd(A_SHADOW + 12'(4 * i), d);
      if (d !== ((i == 10) ? expW : fuseInit(i))) bad++;
    end
    chk("R10 shadow mismatches", bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule